// File: doc/BRIEF.md
# Global Shutter Exposure Sequencer

This block produces the control strobes that a global-shutter pixel array needs. The length of exposure is set only by the moment the pixel-reset strobe is released. Exposure ends when the sample strobe rises. A fixed store sequence then copies every pixel's charge into its in-pixel memory. The same sequence hands the frame to a separate readout engine through a one-cycle start pulse. The block has no other coupling to readout.

There are two modes. In overlapped mode, frames repeat with a programmed period, and the next exposure runs while the readout engine still reads the previous frame. In triggered mode, a rising edge on the trigger starts a single exposure of the programmed length. Exposure and readout then take turns. Before any store sequence begins, the block checks the readout-busy flag, so memory that is still being read is never overwritten. If the flag is high, the exposure is stretched and a sticky overrun flag is raised.

Top module: `gs_expo_seq`

## Requirements
- R1: While reset is active and after reset until a frame or trigger begins, the outputs are `pix_rst_o`=1, `mem_hold_o`=1, and `prech_o`, `samp_o`, `rd_start_o`, `overrun_o` all 0.
- R2: With `trig_mode_i`=0 (overlapped), each frame starts with `pix_rst_o` high for H = F − E − W − 1 cycles. If no stall occurs, consecutive rising edges of `pix_rst_o` are exactly F cycles apart.
- R3: The exposure E is the number of cycles from the first cycle with `pix_rst_o` low to the first cycle with `samp_o` high, and it equals the clamped exposure setting.
- R4: The store sequence runs in this order. `mem_hold_o` drops for one cycle alone. Then `prech_o` is high for W cycles, then `samp_o` is high for W cycles, then `mem_hold_o` returns high. W is `strobe_w_i`, or 1 when `strobe_w_i` is 0. `prech_o` and `samp_o` are never high together.
- R5: `rd_start_o` is a one-cycle pulse. It falls in the cycle in which `mem_hold_o` returns high, directly after the last `samp_o` cycle.
- R6: If `rd_busy_i` is high when the exposure would end, the store sequence is delayed until the first clock edge that sees `rd_busy_i` low. While it waits, `pix_rst_o` stays low. `overrun_o` goes to 1 and stays there until reset.
- R7: With `trig_mode_i`=1 (triggered), a rising edge of `trig_i` seen while idle and with `rd_busy_i` low makes `pix_rst_o` go low in the next cycle. Trigger edges during a frame or while `rd_busy_i` is high are ignored. After the start pulse the block returns to idle with `pix_rst_o` high.
- R8: The effective frame period is F = max(`frame_len_i`, 2W+4). E is `expo_len_i` clamped up to at least W+2. In overlapped mode E is also clamped down to at most F − W − 2.
- R9: A change of `trig_mode_i` aborts any frame. By the next cycle the outputs are in the R1 idle state, with `overrun_o` kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_mode_i | input | 1 | 0 = overlapped frames, 1 = triggered single exposure |
| trig_i | input | 1 | Trigger; rising edge starts an exposure in triggered mode |
| frame_len_i | input | CNT_W | Frame period in cycles (overlapped mode) |
| expo_len_i | input | CNT_W | Exposure length in cycles |
| strobe_w_i | input | SW_W | Width of the precharge and sample pulses |
| rd_busy_i | input | 1 | Readout engine still reading in-pixel memory |
| pix_rst_o | output | 1 | Pixel reset strobe; its falling edge begins exposure |
| mem_hold_o | output | 1 | In-pixel memory hold, low during the store sequence |
| prech_o | output | 1 | Memory precharge strobe |
| samp_o | output | 1 | Sample strobe; its rising edge ends exposure |
| rd_start_o | output | 1 | One-cycle pulse that starts readout of the stored frame |
| overrun_o | output | 1 | Sticky flag: a store sequence had to wait for readout |

## Verification
The critical case is when the end of an exposure and a busy readout land in the same cycle. The store decision and the busy flag are then sampled on the same edge. The bench provokes this by giving the modelled readout engine a busy time longer than a frame. It then checks, cycle by cycle, that the memory-hold drop waits for the first edge with busy low, that the reset strobe stays low, and that the overrun flag latches. A second collision, a trigger edge arriving while readout is still busy, is provoked in triggered mode. It is judged by the reset strobe staying high until a later trigger.

// File: rtl/gs_pkg.sv
package gs_pkg;
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RST,
        PH_EXPO,
        PH_WAIT,
        PH_DROP,
        PH_PRE,
        PH_SMP,
        PH_DONE
    } phase_t;
endpackage

// File: rtl/gs_limits.sv
module gs_limits #(
    parameter int CNT_W = 16,
    parameter int SW_W  = 8
) (
    input  logic             trig_mode_i,
    input  logic [CNT_W-1:0] frame_i,
    input  logic [CNT_W-1:0] expo_i,
    input  logic [SW_W-1:0]  strobe_i,
    output logic [CNT_W-1:0] w_o,
    output logic [CNT_W-1:0] hold_o,
    output logic [CNT_W-1:0] expo_o
);
    localparam int XW = CNT_W + 2;

    logic [XW-1:0] w, fmin, f, emin, emax, e, ein;

    always_comb begin
        w    = (strobe_i == '0) ? XW'(1) : XW'(strobe_i);
        fmin = (w << 1) + XW'(4);
        f    = (XW'(frame_i) < fmin) ? fmin : XW'(frame_i);
        emin = w + XW'(2);
        emax = trig_mode_i ? XW'({CNT_W{1'b1}}) : (f - w - XW'(2));
        ein  = XW'(expo_i);
        if (ein < emin)      e = emin;
        else if (ein > emax) e = emax;
        else                 e = ein;
        w_o    = CNT_W'(w);
        hold_o = CNT_W'(f - e - w - XW'(1));
        expo_o = CNT_W'(e - w - XW'(1));
    end
endmodule

// File: rtl/gs_trig_edge.sv
module gs_trig_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    output logic rise_o
);
    logic trig_q, trig_d;

    always_comb begin
        trig_d = trig_i;
        rise_o = trig_i & ~trig_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= 1'b0;
        else        trig_q <= trig_d;
    end
endmodule

// File: rtl/gs_expo_seq.sv
module gs_expo_seq #(
    parameter int CNT_W = 16,
    parameter int SW_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_mode_i,
    input  logic             trig_i,
    input  logic [CNT_W-1:0] frame_len_i,
    input  logic [CNT_W-1:0] expo_len_i,
    input  logic [SW_W-1:0]  strobe_w_i,
    input  logic             rd_busy_i,
    output logic             pix_rst_o,
    output logic             mem_hold_o,
    output logic             prech_o,
    output logic             samp_o,
    output logic             rd_start_o,
    output logic             overrun_o
);
    import gs_pkg::*;

    typedef struct packed {
        phase_t           ph;
        logic [CNT_W-1:0] cnt;
        logic             mode;
        logic             ovr;
    } seq_t;

    seq_t st_d, st_q;
    logic [CNT_W-1:0] w_len, hold_len, expo_len;
    logic             trig_rise;

    gs_limits #(.CNT_W(CNT_W), .SW_W(SW_W)) u_lim (
        .trig_mode_i (trig_mode_i),
        .frame_i     (frame_len_i),
        .expo_i      (expo_len_i),
        .strobe_i    (strobe_w_i),
        .w_o         (w_len),
        .hold_o      (hold_len),
        .expo_o      (expo_len)
    );

    gs_trig_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_i (trig_i),
        .rise_o (trig_rise)
    );

    always_comb begin
        st_d      = st_q;
        st_d.mode = trig_mode_i;
        if (trig_mode_i != st_q.mode) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
        end else begin
            case (st_q.ph)
                PH_IDLE: begin
                    if (!trig_mode_i) begin
                        st_d.ph  = PH_RST;
                        st_d.cnt = hold_len - 1'b1;
                    end else if (trig_rise && !rd_busy_i) begin
                        st_d.ph  = PH_EXPO;
                        st_d.cnt = expo_len - 1'b1;
                    end
                end
                PH_RST: begin
                    if (st_q.cnt == '0) begin
                        st_d.ph  = PH_EXPO;
                        st_d.cnt = expo_len - 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                PH_EXPO: begin
                    if (st_q.cnt != '0) begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end else if (rd_busy_i) begin
                        st_d.ph  = PH_WAIT;
                        st_d.ovr = 1'b1;
                    end else begin
                        st_d.ph = PH_DROP;
                    end
                end
                PH_WAIT: begin
                    if (!rd_busy_i) st_d.ph = PH_DROP;
                end
                PH_DROP: begin
                    st_d.ph  = PH_PRE;
                    st_d.cnt = w_len - 1'b1;
                end
                PH_PRE: begin
                    if (st_q.cnt == '0) begin
                        st_d.ph  = PH_SMP;
                        st_d.cnt = w_len - 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
                PH_SMP: begin
                    if (st_q.cnt == '0) st_d.ph  = PH_DONE;
                    else                st_d.cnt = st_q.cnt - 1'b1;
                end
                PH_DONE: begin
                    if (trig_mode_i) begin
                        st_d.ph = PH_IDLE;
                    end else begin
                        st_d.ph  = PH_RST;
                        st_d.cnt = hold_len - 1'b1;
                    end
                end
                default: st_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= PH_IDLE;
            st_q.cnt  <= '0;
            st_q.mode <= 1'b0;
            st_q.ovr  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        pix_rst_o  = (st_q.ph == PH_IDLE) || (st_q.ph == PH_RST);
        mem_hold_o = !((st_q.ph == PH_DROP) || (st_q.ph == PH_PRE) || (st_q.ph == PH_SMP));
        prech_o    = (st_q.ph == PH_PRE);
        samp_o     = (st_q.ph == PH_SMP);
        rd_start_o = (st_q.ph == PH_DONE);
        overrun_o  = st_q.ovr;
    end

    // R4: memory must be released while either store strobe is active
    p_hold_low_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (prech_o || samp_o) |-> !mem_hold_o);
    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(prech_o && samp_o));
    p_samp_after_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(samp_o) |-> $past(prech_o));
    // R5: readout start is a single cycle, right after sampling
    p_start_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start_o |=> !rd_start_o);
    p_start_after_samp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_start_o |-> $past(samp_o));
    // R6: no store may begin on an edge that saw readout busy
    p_no_store_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_hold_o) |-> !$past(rd_busy_i));
    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);
    // R2: pixel reset and the store strobes never coincide
    p_rst_vs_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_rst_o |-> !(prech_o || samp_o));
endmodule

// File: tb/sim_gs_expo_seq.sv
`timescale 1ns/1ps
module sim_gs_expo_seq;
    localparam int CNT_W = 16;
    localparam int SW_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_mode = 1'b0;
    logic trig = 1'b0;
    logic [CNT_W-1:0] frame_len = '0;
    logic [CNT_W-1:0] expo_len = '0;
    logic [SW_W-1:0]  strobe_w = '0;
    logic rd_busy = 1'b0;
    logic pix_rst, mem_hold, prech, samp, rd_start, overrun;

    always #2 clk = ~clk;

    gs_expo_seq #(.CNT_W(CNT_W), .SW_W(SW_W)) u0 (
        .clk(clk), .rst_n(rst_n), .trig_mode_i(trig_mode), .trig_i(trig),
        .frame_len_i(frame_len), .expo_len_i(expo_len), .strobe_w_i(strobe_w),
        .rd_busy_i(rd_busy), .pix_rst_o(pix_rst), .mem_hold_o(mem_hold),
        .prech_o(prech), .samp_o(samp), .rd_start_o(rd_start), .overrun_o(overrun)
    );

    int errs = 0, checks = 0, cyc = 0;
    int F_cfg = 40, E_cfg = 12, W_cfg = 3, RB = 10;
    bit chk_timing = 0;
    string tag = "R3";

    function automatic int wq();
        return (W_cfg == 0) ? 1 : W_cfg;
    endfunction
    function automatic int fq();
        int fm = 2 * wq() + 4;
        return (F_cfg < fm) ? fm : F_cfg;
    endfunction
    function automatic int eq(input int m);
        int lo = wq() + 2;
        int hi = m ? 65535 : fq() - wq() - 2;
        if (E_cfg < lo) return lo;
        if (E_cfg > hi) return hi;
        return E_cfg;
    endfunction
    function automatic int hq(input int m);
        return fq() - eq(m) - wq() - 1;
    endfunction

    // behavioural reference: position within the current frame timeline
    bit m_act = 0, m_wait = 0, m_ovr = 0, m_mode = 0, m_tprev = 0;
    int m_p = 0, m_A = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_wait = 0; m_ovr = 0; m_mode = 0; m_tprev = 0;
        end else begin
            bit rise;
            int endx;
            rise = trig && !m_tprev;
            m_tprev = trig;
            if (trig_mode != m_mode) begin
                m_act = 0; m_wait = 0;
            end else if (!m_act) begin
                if (!trig_mode) begin
                    m_act = 1; m_p = 0; m_A = hq(0);
                end else if (rise && !rd_busy) begin
                    m_act = 1; m_p = 0; m_A = 0;
                end
            end else begin
                endx = m_A + eq(trig_mode) - wq() - 1;
                if (m_p == endx + 2 * wq() + 1) begin
                    if (!trig_mode) m_p = 0;
                    else            m_act = 0;
                end else if (m_p == endx - 1) begin
                    if (m_wait) begin
                        if (!rd_busy) begin m_wait = 0; m_p = endx; end
                    end else if (rd_busy) begin
                        m_wait = 1; m_ovr = 1;
                    end else begin
                        m_p = endx;
                    end
                end else begin
                    m_p++;
                end
            end
            m_mode = trig_mode;
        end
    end

    int busy_cnt = 0;
    bit prev_pr = 1, prev_samp = 0;
    int c_fall = -1, c_rise = -1;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            int endx, W;
            bit e_pr, e_hold, e_pre, e_smp, e_rs, ok;
            @(negedge clk);
            cyc++;
            W = wq();
            endx = m_A + eq(trig_mode) - W - 1;
            e_pr   = !m_act || (m_p < m_A);
            e_hold = !(m_act && m_p >= endx && m_p <= endx + 2 * W);
            e_pre  = m_act && m_p >= endx + 1 && m_p <= endx + W;
            e_smp  = m_act && m_p >= endx + W + 1 && m_p <= endx + 2 * W;
            e_rs   = m_act && m_p == endx + 2 * W + 1;
            ok = (pix_rst == e_pr) && (mem_hold == e_hold) && (prech == e_pre) &&
                 (samp == e_smp) && (rd_start == e_rs) && (overrun == m_ovr);
            checks++;
            if (!ok) begin
                errs++;
                if (pix_rst != e_pr)   $display("FAIL R2 pix_rst actual=%0d expected=%0d (cycle %0d)", pix_rst, e_pr, cyc);
                if (mem_hold != e_hold) $display("FAIL R4 mem_hold actual=%0d expected=%0d (cycle %0d)", mem_hold, e_hold, cyc);
                if (prech != e_pre)    $display("FAIL R4 prech actual=%0d expected=%0d (cycle %0d)", prech, e_pre, cyc);
                if (samp != e_smp)     $display("FAIL R4 samp actual=%0d expected=%0d (cycle %0d)", samp, e_smp, cyc);
                if (rd_start != e_rs)  $display("FAIL R5 rd_start actual=%0d expected=%0d (cycle %0d)", rd_start, e_rs, cyc);
                if (overrun != m_ovr)  $display("FAIL R6 overrun actual=%0d expected=%0d (cycle %0d)", overrun, m_ovr, cyc);
            end
            // edge-based timing measurements
            if (chk_timing && rst_n) begin
                if (prev_pr && !pix_rst) begin
                    if (!trig_mode && c_rise >= 0)
                        chk(cyc - c_rise == hq(0), "R2", "reset-high length", cyc - c_rise, hq(0));
                    c_fall = cyc;
                end
                if (!prev_pr && pix_rst) begin
                    if (!trig_mode && c_rise >= 0 && c_fall > c_rise)
                        chk(cyc - c_rise == fq(), "R2", "frame period", cyc - c_rise, fq());
                    c_rise = cyc;
                end
                if (!prev_samp && samp && c_fall >= 0)
                    chk(cyc - c_fall == eq(trig_mode), tag, "exposure", cyc - c_fall, eq(trig_mode));
            end
            prev_pr = pix_rst;
            prev_samp = samp;
            // readout engine model
            if (!rst_n) busy_cnt = 0;
            else begin
                if (busy_cnt > 0) busy_cnt--;
                if (rd_start) busy_cnt = RB;
            end
            rd_busy = (busy_cnt > 0);
        end
    endtask

    task automatic restart(input bit m, input int f, input int e, input int w, input int rb, input bit tm, input string t);
        rst_n = 1'b0;
        trig_mode = m; trig = 1'b0;
        F_cfg = f; E_cfg = e; W_cfg = w; RB = rb; chk_timing = tm; tag = t;
        frame_len = CNT_W'(f); expo_len = CNT_W'(e); strobe_w = SW_W'(w);
        c_fall = -1; c_rise = -1; prev_pr = 1; prev_samp = 0;
        run(3);
        rst_n = 1'b1;
    endtask

    task automatic idle_chk(input string req);
        chk(pix_rst == 1 && mem_hold == 1 && !prech && !samp && !rd_start,
            req, "idle strobes {pix_rst,mem_hold,prech,samp,rd_start}",
            {pix_rst, mem_hold, prech, samp, rd_start}, 5'b11000);
    endtask

    bit done = 0;
    initial begin
        // R1: reset state, triggered mode without trigger stays idle
        restart(1, 40, 12, 3, 10, 0, "R3");
        idle_chk("R1");
        run(10);
        idle_chk("R1");
        chk(overrun == 0, "R1", "overrun after reset", overrun, 0);
        // R2 R3 R4 R5: overlapped, readout shorter than a frame
        restart(0, 40, 12, 3, 20, 1, "R3");
        run(200);
        chk(overrun == 0, "R6", "no overrun with short readout", overrun, 0);
        // R6: readout longer than a frame forces stalls
        restart(0, 30, 10, 2, 45, 0, "R3");
        run(200);
        chk(overrun == 1, "R6", "overrun latched", overrun, 1);
        // R8: short exposure, zero strobe width, tiny frame
        restart(0, 5, 1, 0, 2, 1, "R8");
        run(60);
        // R8: exposure longer than the frame allows
        restart(0, 30, 100, 2, 5, 1, "R8");
        run(120);
        // R7: triggered mode
        restart(1, 40, 10, 2, 15, 1, "R3");
        run(4);
        trig = 1; run(2); trig = 0;
        chk(pix_rst == 0, "R7", "exposure started after trigger", pix_rst, 0);
        run(3);
        trig = 1; run(1); trig = 0;     // ignored, frame in progress
        run(5);
        while (!rd_busy) run(1);
        trig = 1; run(1); trig = 0;     // ignored, readout busy
        run(1);
        chk(pix_rst == 1, "R7", "trigger ignored while busy", pix_rst, 1);
        run(20);
        trig = 1; run(1); trig = 0;     // accepted
        run(40);
        // R9: mode change aborts an overlapped frame mid-exposure
        restart(0, 40, 20, 3, 5, 0, "R3");
        while (pix_rst) run(1);
        run(3);
        trig_mode = 1;
        run(1);
        idle_chk("R9");
        run(10);
        idle_chk("R9");
        trig_mode = 0;
        run(80);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule